// File: doc/BRIEF.md
# Matrix Keypad Scanner with Key Tone

This block reads a sixteen-key switch matrix arranged as four rows by four columns. It pulls one column line low at a time and keeps it low for a set number of clock cycles. It then samples the four row lines through a two-stage synchronizer. A key closed at row r and column c pulls row r low while column c is strobed. At the end of each full sweep the block classifies the sweep as no key, exactly one key, or more than one key. For a single key it reports the key's code.

Per-sweep results feed a debounce filter that keeps a four-sweep history. A press is accepted once four sweeps in a row saw the same single key. A release is accepted once four sweeps in a row saw no key. An accepted press loads the output code register, raises the valid flag and latches the matching seven-segment glyph. These outputs hold through the release and change only on the next accepted press.

While a press is held, a divider toggles the buzzer line at a pitch taken from a per-key half-period table. The line drops to low once the release is accepted. By default every key sounds about 330 Hz. A parameter can give each key its own pitch.

Top module: `keypad_tone_ctrl`

## Requirements
- R1: Exactly one bit of `col_n` is low at any time. The low bit walks 0,1,2,3,0,... and each column stays low for `DWELL` clock cycles.
- R2: A key that pulls `rows_n[r]` low while `col_n[c]` is low gets code 4·r + c. Row 0 is the top row and column 0 is the leftmost, so the top row reads 0..3 and the bottom row C..F.
- R3: A press is accepted only after four consecutive sweeps each saw that one key alone. A contact that lasts 1.5 sweeps or less changes no output.
- R4: `key_code`, `key_valid` and `seg` change only on an accepted press. After a release they keep the last key's values.
- R5: `seg` bit 0..6 drive segments a..g, active high. The glyphs are 0..9, A, lowercase b, C, lowercase d, E and F. Per-segment digit masks (bit n = digit n lit) are: a 0xD7ED, b 0x279F, c 0x2FFB, d 0x7B6D, e 0xFD45, f 0xDF71, g 0xEF7C.
- R6: `buzz` toggles only while a press is held. It is low from the cycle after the release is accepted, which is after four consecutive sweeps with no key.
- R7: With `PER_KEY_PITCH` = 0, each steady half-period of `buzz` is floor(`CLK_HZ` / 660) cycles for every key.
- R8: With `PER_KEY_PITCH` = 1, key k has a steady half-period of floor(`CLK_HZ` / (2·(330 + 20·k))) cycles.
- R9: A sweep with two or more rows low on one strobe, or with keys in more than one column, counts as no valid press. Holding such a combination leaves the code, valid flag and segments unchanged and starts no tone.
- R10: During and after reset, `col_n` = 4'b1110 and `key_code` = 0. `key_valid`, `seg` and `buzz` are all zero until the first accepted press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rows_n | input | 4 | Row sense lines, low when a closed key meets the strobed column |
| col_n | output | 4 | Column strobes, one low at a time |
| key_code | output | 4 | Code of the last accepted key |
| key_valid | output | 1 | High once any press has been accepted |
| seg | output | 7 | Seven-segment pattern for `key_code`, a..g on bits 0..6 |
| buzz | output | 1 | Square wave for the buzzer while a key is held |

## Verification
A press or release is decided at the end of a sweep, and a sweep lasts 4·`DWELL` cycles. A contact applied at any cycle therefore resolves within five sweeps. Two synchronizer stages and three register stages then add a few cycles before the code, flags, segments or buzzer settle. The bench waits seven sweeps after each key change before it samples, and all sampling happens on the falling clock edge. The tone is measured as the gap between two consecutive `buzz` edges after the first edge, which skips the start-up half-period. Short bounces and multi-key chords are held for a known number of sweeps while the bench watches `buzz` every cycle and then compares the held outputs.

// File: rtl/kpt_pkg.sv
package kpt_pkg;

  localparam int unsigned KP_LINES = 4;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned NUM_KEYS = KP_LINES * KP_LINES;
  localparam int unsigned SEG_W    = 7;
  localparam int unsigned BASE_HZ  = 330;
  localparam int unsigned STEP_HZ  = 20;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  // Key code from matrix position: row-major, top-left is zero.
  function automatic code_t make_code(int unsigned row, int unsigned col);
    return code_t'(row * KP_LINES + col);
  endfunction

  // Position of the lowest set bit of a one-hot line vector.
  function automatic int unsigned low_index(logic [KP_LINES-1:0] lines);
    int unsigned idx;
    idx = 0;
    for (int i = KP_LINES - 1; i >= 0; i--) begin
      if (lines[i]) idx = i;
    end
    return idx;
  endfunction

  // Glyph for a hex digit; bit 0 = segment a ... bit 6 = segment g.
  function automatic seg_t glyph(code_t c);
    seg_t s;
    case (c)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

  // Half-period in clock cycles for a key's tone.
  function automatic int unsigned tone_half(int unsigned clk_hz, bit per_key,
                                            int unsigned key);
    int unsigned freq;
    int unsigned half;
    freq = BASE_HZ + (per_key ? STEP_HZ * key : 0);
    half = clk_hz / (2 * freq);
    return (half < 1) ? 1 : half;
  endfunction

endpackage

// File: rtl/kpt_scan.sv
module kpt_scan
  import kpt_pkg::*;
#(
  parameter int unsigned DWELL = 1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [KP_LINES-1:0] rows_n,
  output logic [KP_LINES-1:0] col_n,
  output logic                scan_done,
  output logic                scan_single,
  output logic                scan_none,
  output code_t               scan_code
);

  localparam int unsigned DW_W  = $clog2(DWELL + 1);
  localparam int unsigned CI_W  = $clog2(KP_LINES);
  localparam int unsigned CNT_W = $clog2(KP_LINES + 1);

  logic [DW_W-1:0]     dcnt;
  logic [CI_W-1:0]     cidx;
  logic [KP_LINES-1:0] rsync1, rsync2;
  logic [1:0]          hits, hits_nx;
  code_t               acc_code, code_nx;
  logic                dwell_last, last_col;
  logic [KP_LINES-1:0] row_low;
  logic [CNT_W-1:0]    nlow;

  assign dwell_last = (dcnt == DW_W'(DWELL - 1));
  assign last_col   = dwell_last && (cidx == CI_W'(KP_LINES - 1));
  assign row_low    = ~rsync2;
  assign nlow       = CNT_W'($countones(row_low));
  assign col_n      = ~(KP_LINES'(1) << cidx);

  // Accumulate this strobe's rows into the sweep result.
  always_comb begin
    hits_nx = hits;
    code_nx = acc_code;
    if (dwell_last) begin
      if (nlow == CNT_W'(1)) begin
        hits_nx = (hits == 2'd0) ? 2'd1 : 2'd2;
        code_nx = make_code(low_index(row_low), cidx);
      end else if (nlow > CNT_W'(1)) begin
        hits_nx = 2'd2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt        <= '0;
      cidx        <= '0;
      rsync1      <= '1;
      rsync2      <= '1;
      hits        <= '0;
      acc_code    <= '0;
      scan_done   <= 1'b0;
      scan_single <= 1'b0;
      scan_none   <= 1'b0;
      scan_code   <= '0;
    end else begin
      rsync1    <= rows_n;
      rsync2    <= rsync1;
      scan_done <= 1'b0;
      if (dwell_last) begin
        dcnt <= '0;
        cidx <= cidx + 1'b1;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
      if (last_col) begin
        hits        <= '0;
        acc_code    <= '0;
        scan_done   <= 1'b1;
        scan_single <= (hits_nx == 2'd1);
        scan_none   <= (hits_nx == 2'd0);
        scan_code   <= code_nx;
      end else begin
        hits     <= hits_nx;
        acc_code <= code_nx;
      end
    end
  end

  assert_one_col_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(~col_n) == 1);

  assert_col_dwell_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(col_n) |-> $past(dwell_last));

  assert_scan_class_R9: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> !(scan_single && scan_none));

endmodule

// File: rtl/kpt_debounce.sv
module kpt_debounce
  import kpt_pkg::*;
#(
  parameter int unsigned HIST = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  scan_done,
  input  logic  scan_single,
  input  logic  scan_none,
  input  code_t scan_code,
  output logic  press_evt,
  output logic  held,
  output code_t held_code
);

  localparam logic [HIST-1:0] FULL = '1;

  logic [HIST-1:0] phist, rhist, phist_nx, rhist_nx;
  code_t           cand;

  // Press history counts consecutive single-key sweeps of one code.
  always_comb begin
    if (!scan_single)
      phist_nx = '0;
    else if (scan_code == cand)
      phist_nx = {phist[HIST-2:0], 1'b1};
    else
      phist_nx = HIST'(1);
    rhist_nx = {rhist[HIST-2:0], scan_none};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phist     <= '0;
      rhist     <= '0;
      cand      <= '0;
      held      <= 1'b0;
      held_code <= '0;
      press_evt <= 1'b0;
    end else begin
      press_evt <= 1'b0;
      if (scan_done) begin
        if (scan_single) cand <= scan_code;
        if (!held && phist_nx == FULL) begin
          held      <= 1'b1;
          press_evt <= 1'b1;
          held_code <= scan_code;
          phist     <= '0;
          rhist     <= '0;
        end else if (held && rhist_nx == FULL) begin
          held  <= 1'b0;
          phist <= '0;
          rhist <= '0;
        end else begin
          phist <= phist_nx;
          rhist <= rhist_nx;
        end
      end
    end
  end

  assert_press_from_idle_R3: assert property (@(posedge clk) disable iff (rst)
    press_evt |-> held && !$past(held));

  assert_press_on_sweep_R3: assert property (@(posedge clk) disable iff (rst)
    press_evt |-> $past(scan_done));

endmodule

// File: rtl/kpt_tone.sv
module kpt_tone
  import kpt_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 125_000_000,
  parameter bit          PER_KEY = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  held,
  input  logic  start,
  input  code_t code,
  output logic  buzz
);

  localparam int unsigned MAX_HALF = tone_half(CLK_HZ, 1'b0, 0);
  localparam int unsigned DIV_W    = $clog2(MAX_HALF + 1);

  logic [DIV_W-1:0] half_sel, cnt;

  generate
    if (PER_KEY) begin : g_per_key
      logic [DIV_W-1:0] tab [NUM_KEYS];
      for (genvar k = 0; k < NUM_KEYS; k++) begin : g_ent
        assign tab[k] = DIV_W'(tone_half(CLK_HZ, 1'b1, k));
      end
      assign half_sel = tab[code];
    end else begin : g_single
      assign half_sel = DIV_W'(MAX_HALF);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      buzz <= 1'b0;
    end else if (!held || start) begin
      cnt  <= half_sel - 1'b1;
      buzz <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= half_sel - 1'b1;
      buzz <= ~buzz;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_quiet_release_R6: assert property (@(posedge clk) disable iff (rst)
    !held |=> !buzz);

  assert_rise_when_held_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(buzz) |-> $past(held));

endmodule

// File: rtl/keypad_tone_ctrl.sv
module keypad_tone_ctrl
  import kpt_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 125_000_000,
  parameter int unsigned DWELL         = 1000,
  parameter bit          PER_KEY_PITCH = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] rows_n,
  output logic [3:0] col_n,
  output logic [3:0] key_code,
  output logic       key_valid,
  output logic [6:0] seg,
  output logic       buzz
);

  logic  scan_done, scan_single, scan_none;
  code_t scan_code;
  logic  press_evt, held;
  code_t held_code;

  kpt_scan #(.DWELL(DWELL)) u_scan (
    .clk(clk), .rst(rst), .rows_n(rows_n), .col_n(col_n),
    .scan_done(scan_done), .scan_single(scan_single),
    .scan_none(scan_none), .scan_code(scan_code)
  );

  kpt_debounce #(.HIST(4)) u_deb (
    .clk(clk), .rst(rst), .scan_done(scan_done), .scan_single(scan_single),
    .scan_none(scan_none), .scan_code(scan_code),
    .press_evt(press_evt), .held(held), .held_code(held_code)
  );

  kpt_tone #(.CLK_HZ(CLK_HZ), .PER_KEY(PER_KEY_PITCH)) u_tone (
    .clk(clk), .rst(rst), .held(held), .start(press_evt),
    .code(held_code), .buzz(buzz)
  );

  // Display register: loads only on an accepted press.
  always_ff @(posedge clk) begin
    if (rst) begin
      key_code  <= '0;
      key_valid <= 1'b0;
      seg       <= '0;
    end else if (press_evt) begin
      key_code  <= held_code;
      key_valid <= 1'b1;
      seg       <= glyph(held_code);
    end
  end

  assert_code_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(key_code) |-> $past(press_evt));

  assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    !$fell(key_valid));

  assert_blank_R10: assert property (@(posedge clk) disable iff (rst)
    !key_valid |-> seg == '0);

endmodule

// File: tb/sim_keypad_tone_ctrl.sv
module sim_keypad_tone_ctrl;

  localparam int CLK_HZ = 33000;
  localparam int DWELL  = 4;
  localparam int SCAN   = 4 * DWELL;
  localparam int SETTLE = 7 * SCAN;
  localparam int WD_LIMIT = 150000;

  localparam logic [15:0] SEG_MASK [7] = '{16'hD7ED, 16'h279F, 16'h2FFB,
                                           16'h7B6D, 16'hFD45, 16'hDF71,
                                           16'hEF7C};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] mask = '0;
  always #4 clk = ~clk;

  logic [3:0] rows0, rows1, col0, col1, code0, code1;
  logic       val0, val1, buzz0, buzz1;
  logic [6:0] seg0, seg1;

  function automatic logic [3:0] rows_of(logic [15:0] m, logic [3:0] cn);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      logic low;
      low = 1'b0;
      for (int c = 0; c < 4; c++)
        if (m[i*4+c] && !cn[c]) low = 1'b1;
      r[i] = ~low;
    end
    return r;
  endfunction

  assign rows0 = rows_of(mask, col0);
  assign rows1 = rows_of(mask, col1);

  keypad_tone_ctrl #(.CLK_HZ(CLK_HZ), .DWELL(DWELL), .PER_KEY_PITCH(1'b0)) u0 (
    .clk(clk), .rst(rst), .rows_n(rows0), .col_n(col0), .key_code(code0),
    .key_valid(val0), .seg(seg0), .buzz(buzz0));

  keypad_tone_ctrl #(.CLK_HZ(CLK_HZ), .DWELL(DWELL), .PER_KEY_PITCH(1'b1)) u1 (
    .clk(clk), .rst(rst), .rows_n(rows1), .col_n(col1), .key_code(code1),
    .key_valid(val1), .seg(seg1), .buzz(buzz1));

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  function automatic logic [6:0] exp_seg(int k);
    logic [6:0] s;
    for (int i = 0; i < 7; i++) s[i] = SEG_MASK[i][k];
    return s;
  endfunction

  function automatic int exp_half(bit per_key, int k);
    return CLK_HZ / (2 * (330 + (per_key ? 20 * k : 0)));
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(bit which, output int iv);
    logic prev;
    int lim;
    iv = -1;
    prev = which ? buzz1 : buzz0;
    lim = 0;
    while ((which ? buzz1 : buzz0) == prev && lim < 400) begin
      @(negedge clk); lim++;
    end
    if (lim >= 400) return;
    prev = which ? buzz1 : buzz0;
    iv = 0;
    while ((which ? buzz1 : buzz0) == prev && iv < 400) begin
      @(negedge clk); iv++;
    end
  endtask

  task automatic watch_quiet(int n, output int highs);
    highs = 0;
    repeat (n) begin
      @(negedge clk);
      if (buzz0 || buzz1) highs++;
    end
  endtask

  // Press key k, verify code, glyph and both tones, release, verify hold.
  task automatic press_cycle(int k);
    int iv;
    int highs;
    mask = 16'(1) << k;
    wait_cyc(SETTLE);
    chk("R2 code u0", code0, k);
    chk("R2 code u1", code1, k);
    chk("R4 valid", val0, 1);
    chk("R5 glyph", seg0, exp_seg(k));
    measure(1'b0, iv);
    chk("R7 default half-period", iv, exp_half(1'b0, k));
    measure(1'b1, iv);
    chk("R8 per-key half-period", iv, exp_half(1'b1, k));
    mask = '0;
    wait_cyc(SETTLE);
    watch_quiet(2 * SCAN, highs);
    chk("R6 silent after release", highs, 0);
    chk("R4 code held after release", code0, k);
    chk("R4 glyph held after release", seg1, exp_seg(k));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1..R10 run cycles actual=%0d expected<=%0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int highs;
    int last;
    void'($urandom(32'h5EED_1234));
    wait_cyc(3);
    // R10: reset state
    chk("R10 col_n in reset", col0, 4'b1110);
    chk("R10 seg blank", seg0, 0);
    chk("R10 valid low", val0, 0);
    chk("R10 code zero", code0, 0);
    chk("R10 buzz low", buzz0, 0);
    @(negedge clk) rst = 1'b0;

    // R10: outputs stay quiet with no key
    watch_quiet(3 * SCAN, highs);
    chk("R10 no tone before press", highs, 0);
    chk("R10 still blank", seg0, 0);

    // R1: column walk and dwell
    begin
      logic ok;
      logic [3:0] v;
      int idx;
      int n;
      ok = 1'b1;
      v = col0;
      while (col0 == v) @(negedge clk);
      idx = -1;
      for (int i = 0; i < 4; i++) if (col0 == ~(4'(1) << i)) idx = i;
      if (idx < 0) ok = 1'b0;
      for (int s = 0; s < 12; s++) begin
        v = col0;
        n = 0;
        while (col0 == v && n < 100) begin @(negedge clk); n++; end
        if (n != DWELL) ok = 1'b0;
        idx = (idx + 1) % 4;
        if (col0 != ~(4'(1) << idx)) ok = 1'b0;
      end
      chk("R1 one-low walk with dwell", ok, 1);
    end

    // Directed corner keys, including lowercase glyphs
    press_cycle(0);
    press_cycle(11);
    press_cycle(13);
    press_cycle(15);
    press_cycle(6);
    last = 6;

    // R3: short contact on another key is ignored
    mask = 16'(1) << 9;
    watch_quiet(SCAN + SCAN / 2, highs);
    mask = '0;
    begin
      int h2;
      watch_quiet(SETTLE, h2);
      highs += h2;
    end
    chk("R3 bounce gives no tone", highs, 0);
    chk("R3 bounce leaves code", code0, last);

    // R9: two keys in one column
    mask = (16'(1) << 1) | (16'(1) << 5);
    watch_quiet(SETTLE + SCAN, highs);
    chk("R9 same-column chord no tone", highs, 0);
    chk("R9 same-column chord code", code0, last);
    mask = '0;
    wait_cyc(SETTLE);

    // R9: two keys in different columns
    mask = (16'(1) << 0) | (16'(1) << 15);
    watch_quiet(SETTLE + SCAN, highs);
    chk("R9 cross-column chord no tone", highs, 0);
    chk("R9 cross-column chord glyph", seg0, exp_seg(last));
    mask = '0;
    wait_cyc(SETTLE);

    // Random presses, same key repeated included
    for (int it = 0; it < 20; it++) begin
      int k;
      k = int'($urandom % 16);
      press_cycle(k);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule